// File: doc/BRIEF.md
# Rule-list match stage

This block is one stage of a rule-list pipeline that runs beside a decision-tree pipeline. Each packet arrives with its header fields, a pointer into this stage's rule memory, a count of how many stages still hold rules from its list, and any match already found upstream. The stage reads one or two rules from its own memory, checks each of them against the header in parallel, and keeps the first matching rule in list order. It then passes the packet on with the count lowered by one.

The stage memory has two banks of rule slots. A mode value captured with each packet chooses how the stage reads. In single mode it reads one slot. In pair mode it reads two consecutive addresses of bank 0 through two read ports. In wide mode it reads bank 0 and bank 1 at the same address, which is one double-width word. Once the count reaches zero, the packet no longer reads memory and carries its result, or a no-match flag, to the output unchanged. A write port loads rules into either bank.

Top module: `rlm_stage`

## Requirements
- R1: While reset is low and on the first cycles after it is released, out_valid and out_hit are 0.
- R2: A packet presented with in_valid=1 appears with out_valid=1 exactly two clock edges later. Its source, destination, ports, protocol and pointer are passed through unchanged. Cycles with in_valid=0 give out_valid=0 two edges later.
- R3: With in_mode 0 (single) or 3 (treated as single), only bank 0 at in_ptr is compared.
- R4: With in_mode 1 (pair), bank 0 at in_ptr is compared first and bank 0 at in_ptr+1 second. When in_ptr is DEPTH-1, there is no second rule and nothing wraps to address 0.
- R5: With in_mode 2 (wide), bank 0 at in_ptr is compared first and bank 1 at in_ptr second.
- R6: The rule vector, from MSB to LSB, is {valid(1), src prefix(32), src mask(32), dst prefix(32), dst mask(32), sport low(16), sport high(16), dport low(16), dport high(16), protocol(8), protocol wildcard(1), id(8)}. A rule matches when valid=1, the header addresses agree with both prefixes on every mask bit, both ports lie inside their inclusive ranges, and either the wildcard bit is 1 or the protocol is equal. A rule with valid=0 never matches.
- R7: When both fetched rules match, the first in list order provides out_id.
- R8: When in_hit=1, out_hit=1 and out_id equals in_id, whatever the memory holds.
- R9: When in_rem is not 0, out_rem is in_rem-1 and the rules are compared. When in_rem is 0, no rule is compared and out_rem is 0.
- R10: wr_en=1 stores wr_rule at wr_addr of bank wr_bank (0 or 1). Packets presented from the next cycle on see the new rule.
- R11: Whenever out_hit=0, out_id is 0, even when in_id is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Rule write strobe |
| wr_bank | input | 1 | Bank written: 0 or 1 |
| wr_addr | input | AW | Slot address written |
| wr_rule | input | 210 | Rule vector, layout in R6 |
| in_valid | input | 1 | Packet present |
| in_mode | input | 2 | 0 single, 1 pair, 2 wide, 3 single |
| in_src | input | 32 | Source address |
| in_dst | input | 32 | Destination address |
| in_sport | input | 16 | Source port |
| in_dport | input | 16 | Destination port |
| in_proto | input | 8 | Protocol |
| in_ptr | input | AW | First rule slot of the list in this stage |
| in_rem | input | CNT_W | Stages still holding rules of the list |
| in_hit | input | 1 | Match found upstream |
| in_id | input | 8 | Rule id found upstream |
| out_valid | output | 1 | Packet present |
| out_src | output | 32 | Source address passed on |
| out_dst | output | 32 | Destination address passed on |
| out_sport | output | 16 | Source port passed on |
| out_dport | output | 16 | Destination port passed on |
| out_proto | output | 8 | Protocol passed on |
| out_ptr | output | AW | Pointer passed on |
| out_rem | output | CNT_W | Remaining count after this stage |
| out_hit | output | 1 | Match found so far |
| out_id | output | 8 | Matched rule id, 0 when none |

## Verification
The bench sends pair-mode packets at the last address. A design that wraps the second read would match the rule held at address 0. Packets whose two fetched rules both match show whether the wrong rule wins. The bench also drives port values one below, at, and one above each range bound, so an off-by-one comparison gives a wrong hit. Packets with a zero count or an upstream hit show whether a design overwrites a settled result or lets a stale id leak out with the no-match flag. Rules rewritten between packets show whether a design returns the old contents.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  localparam int IP_W    = 32;
  localparam int PT_W    = 16;
  localparam int PR_W    = 8;
  localparam int ID_W    = 8;
  localparam int LANES   = 2;
  localparam int PICK_W  = (LANES > 1) ? $clog2(LANES) : 1;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_PAIR = 2'd1,
    MODE_WIDE = 2'd2,
    MODE_RSV  = 2'd3
  } mode_t;

  typedef struct packed {
    logic            vld;
    logic [IP_W-1:0] sp;
    logic [IP_W-1:0] sm;
    logic [IP_W-1:0] dp;
    logic [IP_W-1:0] dm;
    logic [PT_W-1:0] slo;
    logic [PT_W-1:0] shi;
    logic [PT_W-1:0] dlo;
    logic [PT_W-1:0] dhi;
    logic [PR_W-1:0] proto;
    logic            pany;
    logic [ID_W-1:0] id;
  } rule_t;

  typedef struct packed {
    logic [IP_W-1:0] src;
    logic [IP_W-1:0] dst;
    logic [PT_W-1:0] sport;
    logic [PT_W-1:0] dport;
    logic [PR_W-1:0] proto;
  } hdr_t;

  localparam int RULE_W = $bits(rule_t);

  // address agrees with prefix on every masked bit
  function automatic logic pfx_ok(input logic [IP_W-1:0] a,
                                  input logic [IP_W-1:0] p,
                                  input logic [IP_W-1:0] m);
    return ((a ^ p) & m) == '0;
  endfunction

  // inclusive range test
  function automatic logic in_span(input logic [PT_W-1:0] v,
                                   input logic [PT_W-1:0] lo,
                                   input logic [PT_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic rule_hit(input rule_t r, input hdr_t h);
    return r.vld
        && pfx_ok(h.src, r.sp, r.sm)
        && pfx_ok(h.dst, r.dp, r.dm)
        && in_span(h.sport, r.slo, r.shi)
        && in_span(h.dport, r.dlo, r.dhi)
        && (r.pany || (r.proto == h.proto));
  endfunction

endpackage

// File: rtl/rlm_bank.sv
module rlm_bank #(
  parameter int DEPTH    = 16,
  parameter int RD_PORTS = 1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  rlm_pkg::rule_t       wdata,
  input  logic                 rd_en,
  input  logic [AW-1:0]        raddr [RD_PORTS],
  output rlm_pkg::rule_t       rdata [RD_PORTS]
);

  rlm_pkg::rule_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd_en) rdata[p] <= mem[raddr[p]];
    end
  end

endmodule

// File: rtl/rlm_lane_sel.sv
module rlm_lane_sel #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  rlm_pkg::mode_t        mode,
  input  logic [AW-1:0]         ptr,
  input  rlm_pkg::rule_t        b0_first,
  input  rlm_pkg::rule_t        b0_next,
  input  rlm_pkg::rule_t        b1_first,
  output rlm_pkg::rule_t        lanes [rlm_pkg::LANES],
  output logic [rlm_pkg::LANES-1:0] live
);
  import rlm_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic pair_ok;
  assign pair_ok = (mode == MODE_PAIR) && (ptr != LAST);

  always_comb begin
    lanes[0] = b0_first;
    lanes[1] = (mode == MODE_PAIR) ? b0_next : b1_first;
    live[0]  = 1'b1;
    live[1]  = pair_ok || (mode == MODE_WIDE);
  end

endmodule

// File: rtl/rlm_match.sv
module rlm_match #(
  parameter int LANES  = rlm_pkg::LANES,
  localparam int PICK_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  enable,
  input  rlm_pkg::hdr_t         hdr,
  input  rlm_pkg::rule_t        lanes [LANES],
  input  logic [LANES-1:0]      live,
  output logic [LANES-1:0]      lane_hit,
  output logic                  new_hit,
  output logic [PICK_W-1:0]     pick,
  output logic [rlm_pkg::ID_W-1:0] new_id
);

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign lane_hit[g] = enable && live[g] && rlm_pkg::rule_hit(lanes[g], hdr);
  end

  // lowest lane index is earliest in list order and wins
  always_comb begin
    new_hit = 1'b0;
    pick    = '0;
    new_id  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_hit[i]) begin
        new_hit = 1'b1;
        pick    = PICK_W'(i);
        new_id  = lanes[i].id;
      end
    end
  end

endmodule

// File: rtl/rlm_stage.sv
module rlm_stage #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int RW    = rlm_pkg::RULE_W,
  localparam int IPW   = rlm_pkg::IP_W,
  localparam int PTW   = rlm_pkg::PT_W,
  localparam int PRW   = rlm_pkg::PR_W,
  localparam int IDW   = rlm_pkg::ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [AW-1:0]   wr_addr,
  input  logic [RW-1:0]   wr_rule,
  input  logic            in_valid,
  input  logic [1:0]      in_mode,
  input  logic [IPW-1:0]  in_src,
  input  logic [IPW-1:0]  in_dst,
  input  logic [PTW-1:0]  in_sport,
  input  logic [PTW-1:0]  in_dport,
  input  logic [PRW-1:0]  in_proto,
  input  logic [AW-1:0]   in_ptr,
  input  logic [CNT_W-1:0] in_rem,
  input  logic            in_hit,
  input  logic [IDW-1:0]  in_id,
  output logic            out_valid,
  output logic [IPW-1:0]  out_src,
  output logic [IPW-1:0]  out_dst,
  output logic [PTW-1:0]  out_sport,
  output logic [PTW-1:0]  out_dport,
  output logic [PRW-1:0]  out_proto,
  output logic [AW-1:0]   out_ptr,
  output logic [CNT_W-1:0] out_rem,
  output logic            out_hit,
  output logic [IDW-1:0]  out_id
);
  import rlm_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // ---------------- read address generation (cycle 0) ----------------
  logic          rd_en;
  logic [AW-1:0] next_ptr;
  logic [AW-1:0] b0_addr [2];
  logic [AW-1:0] b1_addr [1];
  rule_t         b0_q [2];
  rule_t         b1_q [1];
  rule_t         wr_word;

  assign rd_en      = in_valid && (in_rem != '0);
  assign next_ptr   = (in_ptr == LAST) ? '0 : in_ptr + AW'(1);
  assign b0_addr[0] = in_ptr;
  assign b0_addr[1] = next_ptr;
  assign b1_addr[0] = in_ptr;
  assign wr_word    = rule_t'(wr_rule);

  rlm_bank #(.DEPTH(DEPTH), .RD_PORTS(2)) u_bank0 (
    .clk   (clk),
    .we    (wr_en && !wr_bank),
    .waddr (wr_addr),
    .wdata (wr_word),
    .rd_en (rd_en),
    .raddr (b0_addr),
    .rdata (b0_q)
  );

  rlm_bank #(.DEPTH(DEPTH), .RD_PORTS(1)) u_bank1 (
    .clk   (clk),
    .we    (wr_en && wr_bank),
    .waddr (wr_addr),
    .wdata (wr_word),
    .rd_en (rd_en),
    .raddr (b1_addr),
    .rdata (b1_q)
  );

  // ---------------- packet context, stage 1 ----------------
  logic            s1_valid;
  mode_t           s1_mode;
  hdr_t            s1_hdr;
  logic [AW-1:0]   s1_ptr;
  logic [CNT_W-1:0] s1_rem;
  logic            s1_hit;
  logic [IDW-1:0]  s1_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_mode <= mode_t'(in_mode);
    s1_hdr  <= '{src: in_src, dst: in_dst, sport: in_sport,
                 dport: in_dport, proto: in_proto};
    s1_ptr  <= in_ptr;
    s1_rem  <= in_rem;
    s1_hit  <= in_hit;
    s1_id   <= in_id;
  end

  // ---------------- lane selection and compare ----------------
  rule_t             lanes [LANES];
  logic [LANES-1:0]  lane_live;
  logic [LANES-1:0]  lane_hit;
  logic              new_hit;
  logic [PICK_W-1:0] pick;
  logic [IDW-1:0]    new_id;
  logic              cmp_en;
  logic              pick_second;

  rlm_lane_sel #(.DEPTH(DEPTH)) u_sel (
    .mode     (s1_mode),
    .ptr      (s1_ptr),
    .b0_first (b0_q[0]),
    .b0_next  (b0_q[1]),
    .b1_first (b1_q[0]),
    .lanes    (lanes),
    .live     (lane_live)
  );

  assign cmp_en = s1_valid && (s1_rem != '0) && !s1_hit;

  rlm_match #(.LANES(LANES)) u_match (
    .enable   (cmp_en),
    .hdr      (s1_hdr),
    .lanes    (lanes),
    .live     (lane_live),
    .lane_hit (lane_hit),
    .new_hit  (new_hit),
    .pick     (pick),
    .new_id   (new_id)
  );

  assign pick_second = new_hit && (pick == PICK_W'(1));

  // ---------------- result merge ----------------
  logic            res_hit;
  logic [IDW-1:0]  res_id;
  logic [CNT_W-1:0] res_rem;

  always_comb begin
    res_hit = s1_hit || new_hit;
    if (s1_hit)       res_id = s1_id;
    else if (new_hit) res_id = new_id;
    else              res_id = '0;
    res_rem = (s1_rem == '0) ? '0 : s1_rem - CNT_W'(1);
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_id    <= '0;
      out_rem   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_hit   <= s1_valid && res_hit;
      out_id    <= s1_valid ? res_id : '0;
      out_rem   <= s1_valid ? res_rem : '0;
    end
  end

  always_ff @(posedge clk) begin
    out_src   <= s1_hdr.src;
    out_dst   <= s1_hdr.dst;
    out_sport <= s1_hdr.sport;
    out_dport <= s1_hdr.dport;
    out_proto <= s1_hdr.proto;
    out_ptr   <= s1_ptr;
  end

endmodule

// File: rtl/rlm_stage_chk.sv
module rlm_stage_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int IDW  = rlm_pkg::ID_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CNT_W-1:0] in_rem,
  input logic             in_hit,
  input logic [IDW-1:0]   in_id,
  input logic             out_valid,
  input logic [CNT_W-1:0] out_rem,
  input logic             out_hit,
  input logic [IDW-1:0]   out_id,
  input logic             s1_valid,
  input logic [1:0]       s1_mode,
  input logic [AW-1:0]    s1_ptr,
  input logic [1:0]       lane_live,
  input logic [1:0]       lane_hit,
  input logic             pick_second
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_hit);

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R9
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && out_valid) |->
      (out_rem == (($past(in_rem, 2) == '0) ? '0 : $past(in_rem, 2) - CNT_W'(1))));

  // R8
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && out_valid && $past(in_hit, 2)) |->
      (out_hit && out_id == $past(in_id, 2)));

  // R11
  nomatch_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_id == '0));

  // R4
  pair_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == 2'd1 && s1_ptr == AW'(DEPTH - 1)) |-> !lane_live[1]);

  // R3
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_mode == 2'd0 || s1_mode == 2'd3)) |-> !lane_live[1]);

  // R7
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_second |-> !lane_hit[0]);

endmodule

bind rlm_stage rlm_stage_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_rem      (in_rem),
  .in_hit      (in_hit),
  .in_id       (in_id),
  .out_valid   (out_valid),
  .out_rem     (out_rem),
  .out_hit     (out_hit),
  .out_id      (out_id),
  .s1_valid    (s1_valid),
  .s1_mode     (s1_mode),
  .s1_ptr      (s1_ptr),
  .lane_live   (lane_live),
  .lane_hit    (lane_hit),
  .pick_second (pick_second)
);

// File: tb/tb_rlm_stage.sv
module tb_rlm_stage;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = 4;
  localparam int AW    = 4;
  localparam int RW    = 1 + 4*32 + 4*16 + 8 + 1 + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bank = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [RW-1:0] wr_rule = '0;
  logic in_valid = 1'b0;
  logic [1:0] in_mode = '0;
  logic [31:0] in_src = '0, in_dst = '0;
  logic [15:0] in_sport = '0, in_dport = '0;
  logic [7:0] in_proto = '0;
  logic [AW-1:0] in_ptr = '0;
  logic [CNT_W-1:0] in_rem = '0;
  logic in_hit = 1'b0;
  logic [7:0] in_id = '0;
  logic out_valid, out_hit;
  logic [31:0] out_src, out_dst;
  logic [15:0] out_sport, out_dport;
  logic [7:0] out_proto, out_id;
  logic [AW-1:0] out_ptr;
  logic [CNT_W-1:0] out_rem;

  rlm_stage #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_rule(wr_rule), .in_valid(in_valid),
    .in_mode(in_mode), .in_src(in_src), .in_dst(in_dst),
    .in_sport(in_sport), .in_dport(in_dport), .in_proto(in_proto),
    .in_ptr(in_ptr), .in_rem(in_rem), .in_hit(in_hit), .in_id(in_id),
    .out_valid(out_valid), .out_src(out_src), .out_dst(out_dst),
    .out_sport(out_sport), .out_dport(out_dport), .out_proto(out_proto),
    .out_ptr(out_ptr), .out_rem(out_rem), .out_hit(out_hit), .out_id(out_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit vld; bit [31:0] sp, sm, dp, dm; bit [15:0] slo, shi, dlo, dhi;
    bit [7:0] pr; bit pany; bit [7:0] id;
  } brule_t;

  typedef struct {
    bit v; bit [31:0] src, dst; bit [15:0] sp, dp; bit [7:0] pr;
    bit [AW-1:0] ptr; bit [CNT_W-1:0] rem; bit hit; bit [7:0] id; string tag;
  } exp_t;

  brule_t mdl [2][DEPTH];
  exp_t pipe0, pipe1;
  string cur_tag = "R2";
  int checks = 0, errors = 0;

  function automatic brule_t any_rule(input bit [7:0] id);
    brule_t r;
    r.vld = 1; r.sp = 0; r.sm = 0; r.dp = 0; r.dm = 0;
    r.slo = 0; r.shi = 16'hFFFF; r.dlo = 0; r.dhi = 16'hFFFF;
    r.pr = 0; r.pany = 1; r.id = id;
    return r;
  endfunction

  function automatic bit fits(input brule_t r, input bit [31:0] s, input bit [31:0] d,
                              input int sp, input int dp, input int pr);
    if (!r.vld) return 0;
    if ((s & r.sm) != (r.sp & r.sm)) return 0;
    if ((d & r.dm) != (r.dp & r.dm)) return 0;
    if (sp < int'(r.slo) || sp > int'(r.shi)) return 0;
    if (dp < int'(r.dlo) || dp > int'(r.dhi)) return 0;
    if (!r.pany && pr != int'(r.pr)) return 0;
    return 1;
  endfunction

  function automatic exp_t predict();
    exp_t e;
    int bk[$], ad[$];
    e.v = (in_valid === 1'b1);
    e.tag = cur_tag;
    if (!e.v) return e;
    e.src = in_src; e.dst = in_dst; e.sp = in_sport; e.dp = in_dport;
    e.pr = in_proto; e.ptr = in_ptr;
    e.hit = in_hit; e.id = in_hit ? in_id : 8'd0;
    if (in_rem == 0) begin
      e.rem = 0;
      return e;
    end
    e.rem = in_rem - 1;
    bk.push_back(0); ad.push_back(int'(in_ptr));
    if (in_mode == 2'd1 && int'(in_ptr) + 1 < DEPTH) begin
      bk.push_back(0); ad.push_back(int'(in_ptr) + 1);
    end else if (in_mode == 2'd2) begin
      bk.push_back(1); ad.push_back(int'(in_ptr));
    end
    if (!e.hit) begin
      foreach (bk[k]) begin
        if (!e.hit && fits(mdl[bk[k]][ad[k]], in_src, in_dst, int'(in_sport),
                           int'(in_dport), int'(in_proto))) begin
          e.hit = 1; e.id = mdl[bk[k]][ad[k]].id;
        end
      end
    end
    return e;
  endfunction

  task automatic compare(input exp_t e);
    bit bad;
    checks++;
    bad = (out_valid !== e.v);
    if (e.v && !bad)
      bad = (out_hit !== e.hit) || (out_id !== e.id) || (out_rem !== e.rem) ||
            (out_src !== e.src) || (out_dst !== e.dst) || (out_sport !== e.sp) ||
            (out_dport !== e.dp) || (out_proto !== e.pr) || (out_ptr !== e.ptr);
    if (bad) begin
      errors++;
      $display("FAIL %s: got valid=%0d hit=%0d id=%0d rem=%0d ptr=%0d, expected valid=%0d hit=%0d id=%0d rem=%0d ptr=%0d",
               e.tag, out_valid, out_hit, out_id, out_rem, out_ptr,
               e.v, e.hit, e.id, e.rem, e.ptr);
    end
  endtask

  // reference model stepped on every clock
  always @(negedge clk) begin
    exp_t nx;
    nx = predict();
    compare(pipe1);
    pipe1 = pipe0;
    pipe0 = nx;
  end

  task automatic wr(input bit b, input int a, input brule_t r);
    wr_en = 1; wr_bank = b; wr_addr = AW'(a);
    wr_rule = {r.vld, r.sp, r.sm, r.dp, r.dm, r.slo, r.shi, r.dlo, r.dhi, r.pr, r.pany, r.id};
    mdl[b][a] = r;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic send(input string tag, input int mode, input bit [31:0] s,
                      input bit [31:0] d, input int sp, input int dp, input int pr,
                      input int ptr, input int rem, input bit hit, input int id);
    cur_tag = tag;
    in_valid = 1; in_mode = 2'(mode); in_src = s; in_dst = d;
    in_sport = 16'(sp); in_dport = 16'(dp); in_proto = 8'(pr);
    in_ptr = AW'(ptr); in_rem = CNT_W'(rem); in_hit = hit; in_id = 8'(id);
    @(posedge clk); #1;
    in_valid = 0; cur_tag = "R2";
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    brule_t r;
    int ptrs[6] = '{0, 1, 4, 5, 14, 15};
    bit [31:0] srcs[3] = '{32'h0A000001, 32'h0B000001, 32'h01020304};
    bit [31:0] dsts[2] = '{32'hC0A80105, 32'h08080808};
    int sps[5] = '{999, 1000, 2000, 2001, 1500};
    int dps[3] = '{80, 81, 443};
    pipe0.v = 0; pipe1.v = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet while in reset
    checks++;
    if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%0d hit=%0d expected 0 0", out_valid, out_hit);
    end
    rst_n = 1;
    idle(2);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%0d after reset expected 0", out_valid);
    end

    // R10: clear both banks, then load rules
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) begin
        r = any_rule(8'd0); r.vld = 0; wr(b[0], a, r);
      end
    r = any_rule(11); r.sp = 32'h0A000000; r.sm = 32'hFF000000; r.pr = 6; r.pany = 0;
    wr(0, 0, r);
    wr(0, 1, any_rule(12));
    r = any_rule(13); r.dp = 32'hC0A80100; r.dm = 32'hFFFFFF00; r.dlo = 80; r.dhi = 80;
    wr(1, 0, r);
    r = any_rule(30); r.vld = 0; wr(0, 4, r);
    r = any_rule(31); r.sp = 32'h01020304; r.sm = 32'hFFFFFFFF; r.slo = 1000; r.shi = 2000;
    wr(0, 5, r);
    r = any_rule(32); r.dlo = 443; r.dhi = 443; r.pr = 17; r.pany = 0;
    wr(1, 4, r);
    r = any_rule(20); r.pr = 17; r.pany = 0; wr(0, 15, r);
    wr(1, 15, any_rule(21));

    // R3 single mode reads one slot only
    send("R3", 0, 32'h0A010203, 32'h08080808, 5, 5, 6, 0, 2, 0, 0);
    send("R3", 0, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 2, 0, 0);
    // R4 pair mode, consecutive addresses
    send("R4", 1, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 2, 0, 0);
    // R7 both lanes match, first wins
    send("R7", 1, 32'h0A010203, 32'h08080808, 5, 5, 6, 0, 2, 0, 0);
    // R5 wide mode second lane from bank 1
    send("R5", 2, 32'h0B010203, 32'hC0A80105, 5, 80, 6, 0, 1, 0, 0);
    send("R7", 2, 32'h0A010203, 32'hC0A80105, 5, 80, 6, 0, 1, 0, 0);
    send("R6", 2, 32'h0B010203, 32'hC0A80105, 5, 81, 6, 0, 1, 0, 0);
    // R4 last address: no wrap to slot 0
    send("R4", 1, 32'h0A010203, 32'h08080808, 5, 5, 6, 15, 3, 0, 0);
    send("R4", 1, 32'h0A010203, 32'h08080808, 5, 5, 17, 15, 3, 0, 0);
    send("R5", 2, 32'h0A010203, 32'h08080808, 5, 5, 6, 15, 3, 0, 0);
    // R6 invalid slot skipped, range bounds, exact host mask
    send("R6", 1, 32'h01020304, 32'h08080808, 1000, 5, 6, 4, 1, 0, 0);
    send("R6", 1, 32'h01020304, 32'h08080808, 2000, 5, 6, 4, 1, 0, 0);
    send("R6", 1, 32'h01020304, 32'h08080808, 999, 5, 6, 4, 1, 0, 0);
    send("R6", 1, 32'h01020304, 32'h08080808, 2001, 5, 6, 4, 1, 0, 0);
    send("R6", 1, 32'h01020305, 32'h08080808, 1500, 5, 6, 4, 1, 0, 0);
    send("R6", 2, 32'h0B000001, 32'h08080808, 5, 443, 17, 4, 1, 0, 0);
    send("R6", 2, 32'h0B000001, 32'h08080808, 5, 443, 6, 4, 1, 0, 0);
    // R8 upstream hit is kept
    send("R8", 1, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 2, 1, 77);
    // R9 zero count: no compare
    send("R9", 1, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 0, 0, 0);
    send("R9", 1, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 0, 1, 5);
    // R11 stale id cleared on no-match
    send("R11", 0, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 2, 0, 99);
    send("R11", 0, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 0, 0, 99);
    idle(2);
    // R10 rewritten rules seen by the next packet
    wr(1, 0, any_rule(40));
    send("R10", 2, 32'h0B010203, 32'h08080808, 5, 5, 6, 0, 1, 0, 0);
    r = any_rule(0); r.vld = 0; wr(0, 0, r);
    send("R10", 0, 32'h0A010203, 32'h08080808, 5, 5, 6, 0, 1, 0, 0);
    // R3 mode 3 acts as single
    send("R3", 3, 32'h0A010203, 32'h08080808, 5, 5, 6, 1, 1, 0, 0);
    send("R3", 3, 32'h0A010203, 32'h08080808, 5, 5, 6, 0, 1, 0, 0);
    idle(2);
    wr(0, 0, any_rule(11));

    // R2 mixed traffic with gaps
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 4) == 0) idle(1);
      send("R2", int'($urandom_range(0, 3)), srcs[$urandom_range(0, 2)],
           dsts[$urandom_range(0, 1)], sps[$urandom_range(0, 4)],
           dps[$urandom_range(0, 2)], ($urandom_range(0, 1) != 0) ? 17 : 6,
           ptrs[$urandom_range(0, 5)], int'($urandom_range(0, 3)),
           ($urandom_range(0, 7) == 0), int'($urandom_range(0, 255)));
    end
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule